// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a logical address from a processor into a physical address. The upper bits of the logical address select a page; the lower bits are an offset within the page and pass straight through. The page selects an entry in a small page table held in on-chip registers, and each entry holds a frame number and a presence flag. A small fully associative lookaside cache sits in front of the table, so a recently used page is translated without reading the table.

Every accepted request gets exactly one response, which carries a 2-bit status. A page number at or above the programmed table length is refused as a bound error. A page whose entry is not present is reported as a page fault. Otherwise the status is ok and the response carries the frame joined to the offset. Software fills the table through a write port. Writing an entry with its presence flag cleared invalidates that entry. A separate strobe loads the table-length register.

Top module: `page_xlate_unit`

## Requirements
- R1: On an ok response the physical address is the entry's frame number in the upper bits, with the offset field of the logical address (its low OFS_W bits) copied unchanged into the low bits. OFS_W may be set from 9 to 13.
- R2: After reset every table entry is not present, so any in-range page responds with status 1 (page fault), and the length register holds the full table depth (2**VPN_W).
- R3: A page number greater than or equal to the length register responds with status 2 (bound error) and a zero address. This check takes precedence over both the lookaside cache and the page table.
- R4: An in-range page whose entry has its presence flag at 0 responds with status 1 and a zero address. It is not placed in the lookaside cache.
- R5: A request whose page is in the lookaside cache responds in the cycle after acceptance, with rsp_hit at 1. A miss that needs the table responds one cycle later, with rsp_hit at 0.
- R6: On a miss whose table entry is present, the translation is installed in the lookaside cache. The slot is chosen by a round-robin pointer that starts at slot 0 and advances by one on every install, wrapping after slot TLB_N-1.
- R7: A table write (which updates the frame, or invalidates the entry when tbl_valid is 0) removes any cached copy of that page in the same cycle. The next request for that page therefore misses and returns the new contents.
- R8: A write on the length strobe sets the bound used by every later request. A length of 0 makes every page a bound error.
- R9: req_ready is 1 only while the unit is idle. It falls in the cycle after a request is accepted. rsp_valid is a single-cycle pulse, raised exactly once for each accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Unit idle, request accepted when both high |
| req_laddr | input | VPN_W+OFS_W | Logical address (page number above offset) |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 0 ok, 1 page fault, 2 bound error |
| rsp_paddr | output | PFN_W+OFS_W | Physical address, zero unless ok |
| rsp_hit | output | 1 | Response served from the lookaside cache |
| tbl_we | input | 1 | Page-table write strobe |
| tbl_page | input | VPN_W | Page number of the entry written |
| tbl_frame | input | PFN_W | Frame number written |
| tbl_valid | input | 1 | Presence flag written (0 invalidates) |
| len_we | input | 1 | Length-register write strobe |
| len_value | input | VPN_W+1 | New table length in entries |

## Verification
The bench builds the unit with OFS_W at its minimum of 9, VPN_W of 4 (16 pages), PFN_W of 6 and TLB_N of 4. With only four cache slots, a fifth distinct page forces round-robin eviction within a few requests, and the order of the evictions can be seen through rsp_hit. With sixteen pages, the length register can be moved below a page that is still cached, which shows that the bound check overrides a cache hit. Offsets of all zeros and all ones in the narrow 9-bit field check the pass-through at both ends.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [1:0] {
        XS_OK    = 2'd0,
        XS_FAULT = 2'd1,
        XS_BOUND = 2'd2
    } xstat_e;

endpackage

// File: rtl/xlat_page_table.sv
module xlat_page_table #(
    parameter int VPN_W = 4,
    parameter int PFN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PFN_W-1:0] wr_pfn,
    input  logic             wr_vld,
    input  logic [VPN_W-1:0] rd_vpn,
    output logic             rd_vld,
    output logic [PFN_W-1:0] rd_pfn
);

    localparam int DEPTH = 1 << VPN_W;

    typedef struct packed {
        logic             vld;
        logic [PFN_W-1:0] pfn;
    } pte_t;

    typedef struct packed {
        pte_t [DEPTH-1:0] ent;
    } pt_state_t;

    pt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ent[wr_vpn].vld = wr_vld;
            st_d.ent[wr_vpn].pfn = wr_pfn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_vld = st_q.ent[rd_vpn].vld;
    assign rd_pfn = st_q.ent[rd_vpn].pfn;

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
    parameter int N     = 4,
    parameter int VPN_W = 4,
    parameter int PFN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    input  logic             flush_en,
    input  logic [VPN_W-1:0] flush_vpn,
    input  logic             ins_en,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [PFN_W-1:0] ins_pfn
);

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic             vld;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
    } tlbe_t;

    typedef struct packed {
        tlbe_t [N-1:0]    ent;
        logic [IDX_W-1:0] rr;
    } tlb_state_t;

    tlb_state_t st_d, st_q;

    logic [N-1:0] hit_vec;
    logic [N-1:0] flush_vec;
    logic [N-1:0] dup_vec;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g]   = st_q.ent[g].vld && (st_q.ent[g].vpn == lk_vpn);
        assign flush_vec[g] = st_q.ent[g].vld && (st_q.ent[g].vpn == flush_vpn);
        assign dup_vec[g]   = st_q.ent[g].vld && (st_q.ent[g].vpn == ins_vpn);
    end

    always_comb begin
        lk_pfn = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) lk_pfn = lk_pfn | st_q.ent[i].pfn;
        end
    end

    assign lk_hit = |hit_vec;

    always_comb begin
        st_d = st_q;
        if (flush_en) begin
            for (int i = 0; i < N; i++) begin
                if (flush_vec[i]) st_d.ent[i].vld = 1'b0;
            end
        end
        if (ins_en) begin
            st_d.ent[st_q.rr].vld = 1'b1;
            st_d.ent[st_q.rr].vpn = ins_vpn;
            st_d.ent[st_q.rr].pfn = ins_pfn;
            st_d.rr = (st_q.rr == IDX_W'(N-1)) ? '0 : st_q.rr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Checker state: the page flushed in the previous cycle
    logic [VPN_W-1:0] chk_flush_vpn_q;
    logic [N-1:0]     stale_vec;

    always_ff @(posedge clk) begin
        if (!rst_n) chk_flush_vpn_q <= '0;
        else        chk_flush_vpn_q <= flush_vpn;
    end

    for (genvar g = 0; g < N; g++) begin : g_stale
        assign stale_vec[g] = st_q.ent[g].vld && (st_q.ent[g].vpn == chk_flush_vpn_q);
    end

    AST_TLB_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R5

    AST_TLB_NO_DUP_INSTALL: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |-> !(|dup_vec)); // R6

    AST_TLB_FLUSH_GONE: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_en && !(ins_en && ins_vpn == flush_vpn)) |=> !(|stale_vec)); // R7

endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
    import xlat_pkg::*;
#(
    parameter int VPN_W = 4,
    parameter int OFS_W = 12,
    parameter int PFN_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [VPN_W+OFS_W-1:0] req_laddr,
    output logic                   rsp_valid,
    output logic [1:0]             rsp_status,
    output logic [PFN_W+OFS_W-1:0] rsp_paddr,
    output logic                   rsp_hit,
    input  logic                   len_we,
    input  logic [VPN_W:0]         len_value,
    input  logic                   tbl_we,
    input  logic [VPN_W-1:0]       tbl_page,
    output logic [VPN_W-1:0]       lk_vpn,
    input  logic                   tlb_hit,
    input  logic [PFN_W-1:0]       tlb_pfn,
    input  logic                   pt_vld,
    input  logic [PFN_W-1:0]       pt_pfn,
    output logic                   ins_en,
    output logic [VPN_W-1:0]       ins_vpn,
    output logic [PFN_W-1:0]       ins_pfn
);

    localparam int LA_W  = VPN_W + OFS_W;
    localparam int PA_W  = PFN_W + OFS_W;
    localparam int LEN_W = VPN_W + 1;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOOK = 2'd1,
        PH_WALK = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e          phase;
        logic [LA_W-1:0] laddr;
        logic [LEN_W-1:0] len;
        logic            rvalid;
        xstat_e          rstat;
        logic [PA_W-1:0] rpaddr;
        logic            rhit;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    logic [VPN_W-1:0] vpn;
    logic [OFS_W-1:0] ofs;
    logic             in_range;

    assign vpn      = st_q.laddr[OFS_W +: VPN_W];
    assign ofs      = st_q.laddr[OFS_W-1:0];
    assign in_range = {1'b0, vpn} < st_q.len;

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        ins_en      = 1'b0;
        if (len_we) st_d.len = len_value;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.laddr = req_laddr;
                    st_d.phase = PH_LOOK;
                end
            end
            PH_LOOK: begin
                if (!in_range) begin
                    st_d.rvalid = 1'b1;
                    st_d.rstat  = XS_BOUND;
                    st_d.rpaddr = '0;
                    st_d.rhit   = 1'b0;
                    st_d.phase  = PH_IDLE;
                end else if (tlb_hit) begin
                    st_d.rvalid = 1'b1;
                    st_d.rstat  = XS_OK;
                    st_d.rpaddr = {tlb_pfn, ofs};
                    st_d.rhit   = 1'b1;
                    st_d.phase  = PH_IDLE;
                end else begin
                    st_d.phase  = PH_WALK;
                end
            end
            PH_WALK: begin
                st_d.rvalid = 1'b1;
                st_d.rhit   = 1'b0;
                st_d.phase  = PH_IDLE;
                if (pt_vld) begin
                    st_d.rstat  = XS_OK;
                    st_d.rpaddr = {pt_pfn, ofs};
                    ins_en      = !(tbl_we && tbl_page == vpn);
                end else begin
                    st_d.rstat  = XS_FAULT;
                    st_d.rpaddr = '0;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.rstat <= XS_OK;
            st_q.len   <= LEN_W'(1 << VPN_W);
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready  = (st_q.phase == PH_IDLE);
    assign rsp_valid  = st_q.rvalid;
    assign rsp_status = st_q.rstat;
    assign rsp_paddr  = st_q.rpaddr;
    assign rsp_hit    = st_q.rhit;
    assign lk_vpn     = vpn;
    assign ins_vpn    = vpn;
    assign ins_pfn    = pt_pfn;

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R9

    AST_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready); // R9

    AST_BOUND_ONLY_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == XS_BOUND) |-> ({1'b0, $past(vpn)} >= $past(st_q.len))); // R3

    AST_LEGAL_NOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != XS_BOUND) |-> ({1'b0, $past(vpn)} < $past(st_q.len))); // R3

    AST_NONOK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != XS_OK) |-> (rsp_paddr == '0)); // R4

    AST_OFS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == XS_OK) |-> (rsp_paddr[OFS_W-1:0] == st_q.laddr[OFS_W-1:0])); // R1

    AST_HIT_IS_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (rsp_status == XS_OK)); // R5

    AST_NO_BAD_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_status != 2'd3)); // R4

endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit
    import xlat_pkg::*;
#(
    parameter int OFS_W = 12,
    parameter int VPN_W = 4,
    parameter int PFN_W = 6,
    parameter int TLB_N = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [VPN_W+OFS_W-1:0] req_laddr,
    output logic                   rsp_valid,
    output logic [1:0]             rsp_status,
    output logic [PFN_W+OFS_W-1:0] rsp_paddr,
    output logic                   rsp_hit,
    input  logic                   tbl_we,
    input  logic [VPN_W-1:0]       tbl_page,
    input  logic [PFN_W-1:0]       tbl_frame,
    input  logic                   tbl_valid,
    input  logic                   len_we,
    input  logic [VPN_W:0]         len_value
);

    logic [VPN_W-1:0] lk_vpn;
    logic             tlb_hit;
    logic [PFN_W-1:0] tlb_pfn;
    logic             pt_vld;
    logic [PFN_W-1:0] pt_pfn;
    logic             ins_en;
    logic [VPN_W-1:0] ins_vpn;
    logic [PFN_W-1:0] ins_pfn;

    xlat_ctrl #(
        .VPN_W(VPN_W),
        .OFS_W(OFS_W),
        .PFN_W(PFN_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_laddr  (req_laddr),
        .rsp_valid  (rsp_valid),
        .rsp_status (rsp_status),
        .rsp_paddr  (rsp_paddr),
        .rsp_hit    (rsp_hit),
        .len_we     (len_we),
        .len_value  (len_value),
        .tbl_we     (tbl_we),
        .tbl_page   (tbl_page),
        .lk_vpn     (lk_vpn),
        .tlb_hit    (tlb_hit),
        .tlb_pfn    (tlb_pfn),
        .pt_vld     (pt_vld),
        .pt_pfn     (pt_pfn),
        .ins_en     (ins_en),
        .ins_vpn    (ins_vpn),
        .ins_pfn    (ins_pfn)
    );

    xlat_tlb #(
        .N    (TLB_N),
        .VPN_W(VPN_W),
        .PFN_W(PFN_W)
    ) u_tlb (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_vpn    (lk_vpn),
        .lk_hit    (tlb_hit),
        .lk_pfn    (tlb_pfn),
        .flush_en  (tbl_we),
        .flush_vpn (tbl_page),
        .ins_en    (ins_en),
        .ins_vpn   (ins_vpn),
        .ins_pfn   (ins_pfn)
    );

    xlat_page_table #(
        .VPN_W(VPN_W),
        .PFN_W(PFN_W)
    ) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tbl_we),
        .wr_vpn (tbl_page),
        .wr_pfn (tbl_frame),
        .wr_vld (tbl_valid),
        .rd_vpn (lk_vpn),
        .rd_vld (pt_vld),
        .rd_pfn (pt_pfn)
    );

endmodule

// File: tb/tb_page_xlate_unit.sv
module tb_page_xlate_unit;

    localparam int OFS_W = 9;
    localparam int VPN_W = 4;
    localparam int PFN_W = 6;
    localparam int TLB_N = 4;
    localparam int PAGES = 1 << VPN_W;
    localparam int LA_W  = VPN_W + OFS_W;
    localparam int PA_W  = PFN_W + OFS_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [LA_W-1:0]  req_laddr = '0;
    logic             rsp_valid;
    logic [1:0]       rsp_status;
    logic [PA_W-1:0]  rsp_paddr;
    logic             rsp_hit;
    logic             tbl_we = 1'b0;
    logic [VPN_W-1:0] tbl_page = '0;
    logic [PFN_W-1:0] tbl_frame = '0;
    logic             tbl_valid = 1'b0;
    logic             len_we = 1'b0;
    logic [VPN_W:0]   len_value = '0;

    page_xlate_unit #(
        .OFS_W(OFS_W), .VPN_W(VPN_W), .PFN_W(PFN_W), .TLB_N(TLB_N)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_paddr(rsp_paddr), .rsp_hit(rsp_hit),
        .tbl_we(tbl_we), .tbl_page(tbl_page), .tbl_frame(tbl_frame), .tbl_valid(tbl_valid),
        .len_we(len_we), .len_value(len_value)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int ecnt = 0;

    typedef struct {
        logic [1:0]      st;
        logic [PA_W-1:0] pa;
        logic            hit;
        int              due;
        string           tag;
    } exp_t;

    exp_t exp_q[$];

    // Reference model state, built from the requirements
    logic [PFN_W-1:0] m_frame [PAGES];
    logic             m_vld   [PAGES];
    int               m_len;
    int               t_vpn   [TLB_N];
    logic             t_vld   [TLB_N];
    int               t_rr;

    task automatic note(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s", msg);
        end
    endtask

    // Monitor: samples 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        ecnt++;
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                note(1'b0, $sformatf("R9 unexpected response status=%0d expected none", rsp_status));
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                note(rsp_status == e.st && rsp_paddr == e.pa && rsp_hit == e.hit && ecnt == e.due,
                     $sformatf("%s status=%0d paddr=%h hit=%0d at=%0d expected status=%0d paddr=%h hit=%0d at=%0d",
                               e.tag, rsp_status, rsp_paddr, rsp_hit, ecnt, e.st, e.pa, e.hit, e.due));
            end
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (exp_q.size() != 0 || !req_ready) @(negedge clk);
    endtask

    // Driver: predicts, queues the expectation, issues the request
    task automatic xlate(input int page, input int ofs, input string tag);
        exp_t e;
        int   lat;
        bit   found;
        wait_idle();
        found = 1'b0;
        e.tag = tag;
        if (page >= m_len) begin
            e.st = 2'd2; e.pa = '0; e.hit = 1'b0; lat = 2;
        end else begin
            for (int i = 0; i < TLB_N; i++) if (t_vld[i] && t_vpn[i] == page) found = 1'b1;
            if (found) begin
                e.st = 2'd0; e.pa = {m_frame[page], OFS_W'(ofs)}; e.hit = 1'b1; lat = 2;
            end else if (m_vld[page]) begin
                e.st = 2'd0; e.pa = {m_frame[page], OFS_W'(ofs)}; e.hit = 1'b0; lat = 3;
                t_vpn[t_rr] = page; t_vld[t_rr] = 1'b1; t_rr = (t_rr + 1) % TLB_N;
            end else begin
                e.st = 2'd1; e.pa = '0; e.hit = 1'b0; lat = 3;
            end
        end
        e.due = ecnt + lat;
        exp_q.push_back(e);
        req_valid = 1'b1;
        req_laddr = {VPN_W'(page), OFS_W'(ofs)};
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        note(!req_ready, $sformatf("R9 req_ready after accept=%0d expected 0", req_ready));
    endtask

    task automatic tbl_write(input int page, input int frame, input bit vld);
        wait_idle();
        tbl_we = 1'b1; tbl_page = VPN_W'(page); tbl_frame = PFN_W'(frame); tbl_valid = vld;
        @(negedge clk);
        tbl_we = 1'b0;
        m_frame[page] = PFN_W'(frame);
        m_vld[page] = vld;
        for (int i = 0; i < TLB_N; i++) if (t_vpn[i] == page) t_vld[i] = 1'b0;
    endtask

    task automatic len_write(input int len);
        wait_idle();
        len_we = 1'b1; len_value = (VPN_W+1)'(len);
        @(negedge clk);
        len_we = 1'b0;
        m_len = len;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < PAGES; i++) begin m_frame[i] = '0; m_vld[i] = 1'b0; end
        for (int i = 0; i < TLB_N; i++) begin t_vpn[i] = 0; t_vld[i] = 1'b0; end
        t_rr = 0;
        m_len = PAGES;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        note(req_ready == 1'b1 && rsp_valid == 1'b0,
             $sformatf("R9 reset ready=%0d rsp_valid=%0d expected 1/0", req_ready, rsp_valid));

        // R2: entries cleared, length at full depth
        xlate(0, 0, "R2 page0 after reset");
        xlate(15, 3, "R2 top page after reset");

        // R1/R5/R6: fill table, misses then hits
        for (int p = 0; p < PAGES; p++) tbl_write(p, (p * 3 + 5) % 64, 1'b1);
        xlate(0, 0,   "R1 page0 offset zero miss");
        xlate(1, 511, "R1 page1 offset all ones miss");
        xlate(2, 170, "R5 page2 miss");
        xlate(3, 85,  "R5 page3 miss");
        xlate(0, 511, "R5 page0 hit");
        xlate(3, 1,   "R5 page3 hit");

        // R6: round-robin eviction
        xlate(4, 7,  "R6 page4 evicts slot0");
        xlate(0, 9,  "R6 page0 evicted miss");
        xlate(2, 2,  "R6 page2 still cached");
        xlate(1, 4,  "R6 page1 evicted miss");
        xlate(4, 6,  "R6 page4 still cached");

        // R7: write and invalidate flush cached copies
        tbl_write(4, 60, 1'b1);
        xlate(4, 33, "R7 page4 rewritten");
        tbl_write(2, 0, 1'b0);
        xlate(2, 5,  "R7 page2 invalidated");
        xlate(2, 5,  "R4 page2 fault not cached");
        tbl_write(2, 41, 1'b1);
        xlate(2, 8,  "R7 page2 revalidated");

        // R3/R8: length bound over cache and table
        len_write(4);
        xlate(4, 1,  "R3 cached page4 beyond length");
        xlate(9, 1,  "R3 page9 beyond length");
        xlate(3, 12, "R8 page3 within length");
        len_write(0);
        xlate(0, 0,  "R8 length zero page0");
        len_write(16);
        xlate(15, 100, "R8 full length page15");
        xlate(15, 101, "R5 page15 hit");

        wait_idle();
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule